// File: doc/BRIEF.md
# ALU with Branch-Condition Evaluation

A purely combinational 32-bit arithmetic and logic unit for a single-issue, five-stage style integer core. The main control decoder sends it a 4-bit operation code. It also receives two data operands, the 6-bit function field of register-register instructions and a separate 5-bit shift amount. It returns a data result and a single branch-condition flag.

Operation code 0 passes the choice of operation to the function field. Codes 7 to 12 cover the immediate-form arithmetic, compare and logic operations, and code 7 also forms load and store addresses. Codes 1 to 6 turn the unit into a branch comparator. These codes leave the result at zero and drive only the flag, which the program-counter logic downstream consumes.

Top module: `br_alu`

## Requirements
- R1: Code 7 drives `a_i + b_i` modulo 2^32 on `result_o`. There is no overflow indication of any kind.
- R2: Code 8 outputs 1 when `a_i < b_i` as signed two's-complement values, else 0. Code 9 does the same comparison unsigned. The upper 31 result bits are always 0 for both codes.
- R3: Codes 10, 11 and 12 drive the bitwise AND, OR and XOR of the operands, in that order.
- R4: With code 0, the function field selects the operation: 0x21 add, 0x23 `a_i - b_i` (wrapping), 0x24 AND, 0x25 OR, 0x26 XOR, 0x2A signed set-less-than and 0x2B unsigned set-less-than.
- R5: With code 0, function 0x00 shifts `b_i` left logically by `shamt_i`, 0x02 shifts it right logically and 0x03 shifts it right arithmetically. A shift amount of 0 returns `b_i` unchanged.
- R6: Code 1 raises `cond_o` exactly when bit 31 of `a_i` is 1. Code 2 raises it exactly when that bit is 0.
- R7: Code 5 raises `cond_o` when `a_i` is zero or negative. Code 6 raises it when `a_i` is strictly positive.
- R8: Code 3 raises `cond_o` when `a_i` equals `b_i`. Code 4 raises it when they differ.
- R9: For codes 1 to 6, `result_o` is 0 whatever the operands. For every other code, `cond_o` is 0.
- R10: Codes 13, 14 and 15 drive `result_o` = 0 and `cond_o` = 0. So does code 0 with any function value not listed in R4 or R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc_i | input | 4 | Operation code from the control decoder |
| funct_i | input | 6 | Function field, used only when the code is 0 |
| shamt_i | input | 5 | Shift amount for the shift functions |
| a_i | input | 32 | First operand (first source register) |
| b_i | input | 32 | Second operand (register or extended immediate) |
| result_o | output | 32 | Data result |
| cond_o | output | 1 | Branch condition is true |

## Verification
The bench aims at sign boundaries. The value 0x80000000 separates a design that tests the sign bit from one that tests "nonzero". Zero itself separates the <=0 and >0 predicates, and a design that swaps strict and non-strict comparisons fails there. The operand pair -1 and 1 gives opposite answers for the signed and unsigned set-less-than, so a mixed-up signedness shows at once. The right shift of a negative operand exposes an arithmetic shift that fills with zeros. Operands that differ only in their lowest bit catch an equality test that looks at too few bits. Nonzero operands on the branch codes, and the reserved codes and function values, show whether the result and flag leak values they must not drive.

// File: rtl/br_alu_pkg.sv
package br_alu_pkg;

  localparam int OPC_W   = 4;
  localparam int FUNCT_W = 6;

  typedef enum logic [OPC_W-1:0] {
    OPC_REG  = 4'd0,
    OPC_LTZ  = 4'd1,
    OPC_GEZ  = 4'd2,
    OPC_EQ   = 4'd3,
    OPC_NE   = 4'd4,
    OPC_LEZ  = 4'd5,
    OPC_GTZ  = 4'd6,
    OPC_ADD  = 4'd7,
    OPC_SLT  = 4'd8,
    OPC_SLTU = 4'd9,
    OPC_AND  = 4'd10,
    OPC_OR   = 4'd11,
    OPC_XOR  = 4'd12
  } alu_opc_e;

  localparam logic [FUNCT_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FUNCT_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FUNCT_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FUNCT_W-1:0] FN_ADD  = 6'h21;
  localparam logic [FUNCT_W-1:0] FN_SUB  = 6'h23;
  localparam logic [FUNCT_W-1:0] FN_AND  = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR   = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FUNCT_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FUNCT_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    RES_ZERO, RES_ADD, RES_SUB, RES_AND, RES_OR, RES_XOR,
    RES_SLT, RES_SLTU, RES_SLL, RES_SRL, RES_SRA
  } res_sel_e;

  typedef enum logic [2:0] {
    BR_NONE, BR_LTZ, BR_GEZ, BR_EQ, BR_NE, BR_LEZ, BR_GTZ
  } br_sel_e;

endpackage

// File: rtl/br_alu_dec.sv
module br_alu_dec
  import br_alu_pkg::*;
(
  input  logic [OPC_W-1:0]   opc_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output res_sel_e           res_sel_o,
  output br_sel_e            br_sel_o,
  output logic               sub_o
);

  res_sel_e fn_sel;

  always_comb begin
    case (funct_i)
      FN_SLL:  fn_sel = RES_SLL;
      FN_SRL:  fn_sel = RES_SRL;
      FN_SRA:  fn_sel = RES_SRA;
      FN_ADD:  fn_sel = RES_ADD;
      FN_SUB:  fn_sel = RES_SUB;
      FN_AND:  fn_sel = RES_AND;
      FN_OR:   fn_sel = RES_OR;
      FN_XOR:  fn_sel = RES_XOR;
      FN_SLT:  fn_sel = RES_SLT;
      FN_SLTU: fn_sel = RES_SLTU;
      default: fn_sel = RES_ZERO;
    endcase
  end

  always_comb begin
    res_sel_o = RES_ZERO;
    br_sel_o  = BR_NONE;
    case (opc_i)
      OPC_REG:  res_sel_o = fn_sel;
      OPC_LTZ:  br_sel_o  = BR_LTZ;
      OPC_GEZ:  br_sel_o  = BR_GEZ;
      OPC_EQ:   br_sel_o  = BR_EQ;
      OPC_NE:   br_sel_o  = BR_NE;
      OPC_LEZ:  br_sel_o  = BR_LEZ;
      OPC_GTZ:  br_sel_o  = BR_GTZ;
      OPC_ADD:  res_sel_o = RES_ADD;
      OPC_SLT:  res_sel_o = RES_SLT;
      OPC_SLTU: res_sel_o = RES_SLTU;
      OPC_AND:  res_sel_o = RES_AND;
      OPC_OR:   res_sel_o = RES_OR;
      OPC_XOR:  res_sel_o = RES_XOR;
      default:  ;
    endcase
  end

  // adder subtracts for sub and for equality compare
  assign sub_o = (res_sel_o == RES_SUB) || (br_sel_o == BR_EQ) || (br_sel_o == BR_NE);

endmodule

// File: rtl/br_alu_dp.sv
module br_alu_dp
  import br_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  res_sel_e           res_sel_i,
  input  logic               sub_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               sum_zero_o
);

  logic [DATA_W-1:0] b_op;
  logic [DATA_W-1:0] sum;
  logic              lt_s;
  logic              lt_u;

  assign b_op       = b_i ^ {DATA_W{sub_i}};
  assign sum        = a_i + b_op + {{(DATA_W-1){1'b0}}, sub_i};
  assign sum_zero_o = (sum == '0);
  assign lt_s       = $signed(a_i) < $signed(b_i);
  assign lt_u       = a_i < b_i;

  always_comb begin
    case (res_sel_i)
      RES_ADD,
      RES_SUB:  res_o = sum;
      RES_AND:  res_o = a_i & b_i;
      RES_OR:   res_o = a_i | b_i;
      RES_XOR:  res_o = a_i ^ b_i;
      RES_SLT:  res_o = {{(DATA_W-1){1'b0}}, lt_s};
      RES_SLTU: res_o = {{(DATA_W-1){1'b0}}, lt_u};
      RES_SLL:  res_o = b_i << shamt_i;
      RES_SRL:  res_o = b_i >> shamt_i;
      RES_SRA:  res_o = DATA_W'($signed(b_i) >>> shamt_i);
      default:  res_o = '0;
    endcase
  end

endmodule

// File: rtl/br_alu_cond.sv
module br_alu_cond
  import br_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              sum_zero_i,
  input  br_sel_e           br_sel_i,
  output logic              cond_o
);

  logic a_neg;
  logic a_zero;

  assign a_neg  = a_i[DATA_W-1];
  assign a_zero = (a_i == '0);

  always_comb begin
    case (br_sel_i)
      BR_LTZ:  cond_o = a_neg;
      BR_GEZ:  cond_o = !a_neg;
      BR_EQ:   cond_o = sum_zero_i;
      BR_NE:   cond_o = !sum_zero_i;
      BR_LEZ:  cond_o = a_neg || a_zero;
      BR_GTZ:  cond_o = !a_neg && !a_zero;
      default: cond_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/br_alu.sv
module br_alu
  import br_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [OPC_W-1:0]   opc_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               cond_o
);

  res_sel_e res_sel;
  br_sel_e  br_sel;
  logic     sub;
  logic     sum_zero;

  br_alu_dec u_dec (
    .opc_i     (opc_i),
    .funct_i   (funct_i),
    .res_sel_o (res_sel),
    .br_sel_o  (br_sel),
    .sub_o     (sub)
  );

  br_alu_dp #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_dp (
    .a_i        (a_i),
    .b_i        (b_i),
    .shamt_i    (shamt_i),
    .res_sel_i  (res_sel),
    .sub_i      (sub),
    .res_o      (result_o),
    .sum_zero_o (sum_zero)
  );

  br_alu_cond #(.DATA_W(DATA_W)) u_cond (
    .a_i        (a_i),
    .sum_zero_i (sum_zero),
    .br_sel_i   (br_sel),
    .cond_o     (cond_o)
  );

endmodule

// File: rtl/br_alu_chk.sv
module br_alu_chk #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic [3:0]         opc_i,
  input logic [5:0]         funct_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               cond_o
);

  logic known;
  logic is_br;

  assign known = !$isunknown({opc_i, funct_i, shamt_i, a_i, b_i});
  assign is_br = (opc_i >= 4'd1) && (opc_i <= 4'd6);

  always_comb begin
    if (known) begin
      AST_BR_RES_ZERO: assert (!is_br || result_o == '0); // R9
      AST_NONBR_COND_LOW: assert (is_br || !cond_o); // R9
      AST_RSV_OPC_QUIET: assert (opc_i < 4'd13 || (result_o == '0 && !cond_o)); // R10
      AST_SLT_BOOL: assert (!(opc_i == 4'd8 || opc_i == 4'd9) || result_o[DATA_W-1:1] == '0); // R2
      AST_LTZ_SIGN: assert (opc_i != 4'd1 || cond_o == a_i[DATA_W-1]); // R6
      AST_EQ_MATCH: assert (opc_i != 4'd3 || cond_o == (a_i == b_i)); // R8
      AST_NE_MATCH: assert (opc_i != 4'd4 || cond_o == (a_i != b_i)); // R8
      AST_ADD_WRAP: assert (opc_i != 4'd7 || result_o == a_i + b_i); // R1
    end
  end

endmodule

bind br_alu br_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .opc_i    (opc_i),
  .funct_i  (funct_i),
  .shamt_i  (shamt_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .cond_o   (cond_o)
);

// File: tb/br_alu_tb.sv
module br_alu_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  opc;
  logic [5:0]  funct;
  logic [4:0]  shamt;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] res;
  logic        cond;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  br_alu u_dut (
    .opc_i    (opc),
    .funct_i  (funct),
    .shamt_i  (shamt),
    .a_i      (a),
    .b_i      (b),
    .result_o (res),
    .cond_o   (cond)
  );

  // drive on falling edge, sample 2 ns later (combinational path)
  task automatic apply(input logic [3:0] o, input logic [5:0] f, input logic [4:0] s,
                       input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    opc = o; funct = f; shamt = s; a = x; b = y;
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] exp_res, input logic exp_cond);
    checks++;
    if (res !== exp_res || cond !== exp_cond) begin
      errors++;
      $display("FAIL %s: result=%h cond=%b expected result=%h cond=%b",
               tag, res, cond, exp_res, exp_cond);
    end
  endtask

  task automatic t_reset;
    apply(4'd0, 6'h00, 5'd0, 32'h0, 32'h0);
    check("reset R5", 32'h0, 1'b0);
  endtask

  task automatic t_add;
    apply(4'd7, 6'h3F, 5'd9, 32'hFFFF_FFFF, 32'h2);
    check("R1 wrap", 32'h1, 1'b0);
    apply(4'd7, 6'h00, 5'd0, 32'h7FFF_FFFF, 32'h1);
    check("R1 no trap / R9 flag low", 32'h8000_0000, 1'b0);
  endtask

  task automatic t_slt;
    apply(4'd8, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h1);
    check("R2 signed", 32'h1, 1'b0);
    apply(4'd9, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h1);
    check("R2 unsigned", 32'h0, 1'b0);
    apply(4'd8, 6'h00, 5'd0, 32'h5, 32'h5);
    check("R2 equal", 32'h0, 1'b0);
    apply(4'd9, 6'h00, 5'd0, 32'h1, 32'h8000_0000);
    check("R2 unsigned true", 32'h1, 1'b0);
  endtask

  task automatic t_logic;
    apply(4'd10, 6'h00, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F);
    check("R3 and", 32'h00F0_000F, 1'b0);
    apply(4'd11, 6'h00, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F);
    check("R3 or", 32'hFFF0_0FFF, 1'b0);
    apply(4'd12, 6'h00, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F);
    check("R3 xor", 32'hFF00_0FF0, 1'b0);
  endtask

  task automatic t_reg;
    apply(4'd0, 6'h21, 5'd0, 32'h3, 32'h4);
    check("R4 add", 32'h7, 1'b0);
    apply(4'd0, 6'h23, 5'd0, 32'h3, 32'h4);
    check("R4 sub", 32'hFFFF_FFFF, 1'b0);
    apply(4'd0, 6'h24, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F);
    check("R4 and", 32'h00F0_000F, 1'b0);
    apply(4'd0, 6'h25, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F);
    check("R4 or", 32'hFFF0_0FFF, 1'b0);
    apply(4'd0, 6'h26, 5'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F);
    check("R4 xor", 32'hFF00_0FF0, 1'b0);
    apply(4'd0, 6'h2A, 5'd0, 32'h8000_0000, 32'h0);
    check("R4 slt", 32'h1, 1'b0);
    apply(4'd0, 6'h2B, 5'd0, 32'h8000_0000, 32'h0);
    check("R4 sltu", 32'h0, 1'b0);
  endtask

  task automatic t_shift;
    apply(4'd0, 6'h00, 5'd4, 32'hDEAD_BEEF, 32'h8000_0010);
    check("R5 sll", 32'h0000_0100, 1'b0);
    apply(4'd0, 6'h02, 5'd4, 32'h0, 32'h8000_0010);
    check("R5 srl", 32'h0800_0001, 1'b0);
    apply(4'd0, 6'h03, 5'd4, 32'h0, 32'h8000_0010);
    check("R5 sra", 32'hF800_0001, 1'b0);
    apply(4'd0, 6'h03, 5'd0, 32'h0, 32'h8000_0010);
    check("R5 zero amount", 32'h8000_0010, 1'b0);
    apply(4'd0, 6'h00, 5'd31, 32'h0, 32'h1);
    check("R5 max amount", 32'h8000_0000, 1'b0);
  endtask

  task automatic t_sign;
    apply(4'd1, 6'h21, 5'd0, 32'h8000_0000, 32'h1234);
    check("R6 ltz neg / R9", 32'h0, 1'b1);
    apply(4'd1, 6'h00, 5'd0, 32'h0, 32'hFFFF_FFFF);
    check("R6 ltz zero", 32'h0, 1'b0);
    apply(4'd2, 6'h00, 5'd0, 32'h0, 32'h5);
    check("R6 gez zero", 32'h0, 1'b1);
    apply(4'd2, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h5);
    check("R6 gez neg", 32'h0, 1'b0);
  endtask

  task automatic t_lez_gtz;
    apply(4'd5, 6'h00, 5'd0, 32'h0, 32'h7);
    check("R7 lez zero", 32'h0, 1'b1);
    apply(4'd5, 6'h00, 5'd0, 32'h1, 32'h7);
    check("R7 lez pos", 32'h0, 1'b0);
    apply(4'd5, 6'h00, 5'd0, 32'hFFFF_FFFB, 32'h7);
    check("R7 lez neg", 32'h0, 1'b1);
    apply(4'd6, 6'h00, 5'd0, 32'h1, 32'h7);
    check("R7 gtz pos", 32'h0, 1'b1);
    apply(4'd6, 6'h00, 5'd0, 32'h0, 32'h7);
    check("R7 gtz zero", 32'h0, 1'b0);
    apply(4'd6, 6'h00, 5'd0, 32'h8000_0000, 32'h7);
    check("R7 gtz min", 32'h0, 1'b0);
  endtask

  task automatic t_eq;
    apply(4'd3, 6'h00, 5'd0, 32'h1234, 32'h1234);
    check("R8 eq true", 32'h0, 1'b1);
    apply(4'd3, 6'h00, 5'd0, 32'h1234, 32'h1235);
    check("R8 eq lsb diff", 32'h0, 1'b0);
    apply(4'd4, 6'h00, 5'd0, 32'h1234, 32'h1235);
    check("R8 ne true", 32'h0, 1'b1);
    apply(4'd4, 6'h00, 5'd0, 32'h8000_0000, 32'h8000_0000);
    check("R8 ne equal", 32'h0, 1'b0);
    apply(4'd3, 6'h00, 5'd0, 32'h8000_0000, 32'h0);
    check("R8 eq msb diff", 32'h0, 1'b0);
  endtask

  task automatic t_reserved;
    for (int k = 13; k < 16; k++) begin
      apply(4'(k), 6'h21, 5'd3, 32'hFFFF_FFFF, 32'h8000_0000);
      check("R10 reserved code", 32'h0, 1'b0);
    end
    apply(4'd0, 6'h20, 5'd3, 32'h5, 32'h6);
    check("R10 funct 0x20", 32'h0, 1'b0);
    apply(4'd0, 6'h3F, 5'd3, 32'h5, 32'h6);
    check("R10 funct 0x3F", 32'h0, 1'b0);
    apply(4'd0, 6'h01, 5'd3, 32'h5, 32'h6);
    check("R10 funct 0x01", 32'h0, 1'b0);
  endtask

  initial begin
    opc = '0; funct = '0; shamt = '0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_add();
    t_slt();
    t_logic();
    t_reg();
    t_shift();
    t_sign();
    t_lez_gtz();
    t_eq();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: result=%h cond=%b expected completion", res, cond);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule